// File: doc/BRIEF.md
# Interlocked Pipeline Fork Stage

This stage sits at a branching point of a valid/stall pipeline. Every item it accepts from its single upstream neighbour is copied to a configurable number of downstream branches. All branches see the same data bus and take the item together in one cycle. A branch receives the item in a cycle where it sees its valid high and drives its stall low. Upstream, an item is taken in a cycle where the upstream valid is high and the stage's own stall output is low.

Delivery is all-or-nothing. While any branch holds its stall high, the stage drops the valid to every branch, including the ones that are ready. No branch can therefore take a copy early and then see the same item again. The stage holds up to two items. Its upstream stall comes straight from a register, so the stall never passes combinationally from the downstream side to the upstream side, and the stage still runs at one item per cycle.

Top module: `fork_stage`

## Requirements
- R1: While reset is high, and in the first cycle after it, every bit of `br_valid` and `up_stall` is 0, whatever the other inputs are.
- R2: In any cycle where at least one bit of `br_stall` is 1, every bit of `br_valid` is 0.
- R3: In any cycle where the stage holds an item and every bit of `br_stall` is 0, every bit of `br_valid` is 1. Every `WIDTH`-bit slice of `br_data` (slice i is bits i*WIDTH to i*WIDTH+WIDTH-1) then carries the oldest held item.
- R4: Each branch receives exactly the sequence of accepted upstream items: in order, with no gaps and no repeats.
- R5: `up_stall` is 0 whenever the stage holds no item, even when branch stalls are high.
- R6: An upstream item is accepted only at a clock edge where `up_valid` is 1 and `up_stall` is 0. `up_data` offered while `up_stall` is 1 is never delivered.
- R7: `up_stall` is 1 exactly in the cycles where the stage holds two items. It depends only on registered state.
- R8: An item accepted into an empty stage is offered to the branches in the next cycle.
- R9: While an item is held and not delivered, the head data on `br_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| up_valid | input | 1 | Upstream item present |
| up_data | input | WIDTH | Upstream item |
| up_stall | output | 1 | Stage cannot take an item this cycle |
| br_valid | output | BRANCHES | Per-branch item present |
| br_data | output | BRANCHES*WIDTH | Per-branch copy of the head item |
| br_stall | input | BRANCHES | Per-branch stall |

## Verification
The assertions assume the upstream neighbour obeys the stall. An item offered under `up_stall` is treated as not taken, and the stage writes no slot in that cycle. They also assume the branch stall inputs are valid levels, never X, from the first cycle after reset. The stimulus drives every input from known values at the falling edge. It draws an independent stall for each branch at several densities, and it offers items at random, including while `up_stall` is high. A behavioural queue model predicts the stall, the valids and the head data in every cycle.

// File: rtl/fork_pkg.sv
package fork_pkg;

    localparam int SLOTS = 2;
    localparam int PTR_W = 1;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_ONE   = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;

    function automatic occ_e occ_step(input occ_e cur, input logic ins, input logic rem);
        occ_e nxt;
        nxt = cur;
        case ({ins, rem})
            2'b10: nxt = (cur == OCC_EMPTY) ? OCC_ONE : OCC_FULL;
            2'b01: nxt = (cur == OCC_FULL) ? OCC_ONE : OCC_EMPTY;
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

    function automatic logic occ_holds(input occ_e cur);
        return cur != OCC_EMPTY;
    endfunction

endpackage

// File: rtl/fork_buf.sv
module fork_buf
    import fork_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output occ_e             occ
);

    logic [WIDTH-1:0] slot_q [SLOTS];
    logic [PTR_W-1:0] wr_q;
    logic [PTR_W-1:0] rd_q;
    occ_e             occ_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_q == PTR_W'(g)) begin
                slot_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= OCC_EMPTY;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
            occ_q <= occ_step(occ_q, push, pop);
        end
    end

    assign rdata = slot_q[rd_q];
    assign occ   = occ_q;

    // R6: the parent never writes into a full buffer
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        push |-> occ_q != OCC_FULL);

    // R4: nothing is removed from an empty buffer
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        pop |-> occ_q != OCC_EMPTY);

    // R9: a held head that is not removed keeps its value
    p_head_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (occ_q != OCC_EMPTY && !pop) |=> rdata == $past(rdata));

endmodule

// File: rtl/fork_fanout.sv
module fork_fanout
    import fork_pkg::*;
#(
    parameter int BRANCHES = 2,
    parameter int WIDTH    = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      have,
    input  logic [WIDTH-1:0]          head,
    input  logic [BRANCHES-1:0]       br_stall,
    output logic [BRANCHES-1:0]       br_valid,
    output logic [BRANCHES*WIDTH-1:0] br_data,
    output logic                      fire
);

    logic any_stall;

    assign any_stall = |br_stall;
    assign fire      = have && !any_stall;

    for (genvar b = 0; b < BRANCHES; b++) begin : g_branch
        assign br_valid[b]                = fire;
        assign br_data[b*WIDTH +: WIDTH]  = head;
    end

    // R2: one stalled branch silences every branch
    p_suppress_r2: assert property (@(posedge clk) disable iff (rst)
        (br_stall != '0) |-> br_valid == '0);

    // R3: branches are offered the item together or not at all
    p_together_r3: assert property (@(posedge clk) disable iff (rst)
        (br_valid != '0) |-> &br_valid);

endmodule

// File: rtl/fork_stage.sv
module fork_stage
    import fork_pkg::*;
#(
    parameter int BRANCHES = 2,
    parameter int WIDTH    = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      up_valid,
    input  logic [WIDTH-1:0]          up_data,
    output logic                      up_stall,
    output logic [BRANCHES-1:0]       br_valid,
    output logic [BRANCHES*WIDTH-1:0] br_data,
    input  logic [BRANCHES-1:0]       br_stall
);

    occ_e             occ;
    logic             push;
    logic             fire;
    logic [WIDTH-1:0] head;

    assign up_stall = (occ == OCC_FULL);
    assign push     = up_valid && !up_stall;

    fork_buf #(.WIDTH(WIDTH)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (fire),
        .wdata (up_data),
        .rdata (head),
        .occ   (occ)
    );

    fork_fanout #(.BRANCHES(BRANCHES), .WIDTH(WIDTH)) u_fan (
        .clk      (clk),
        .rst      (rst),
        .have     (occ_holds(occ)),
        .head     (head),
        .br_stall (br_stall),
        .br_valid (br_valid),
        .br_data  (br_data),
        .fire     (fire)
    );

    // R5: a stalled stage is either delivering or blocked by a branch
    p_stall_has_data_r5: assert property (@(posedge clk) disable iff (rst)
        up_stall |-> (br_valid != '0) || (br_stall != '0));

    // R8: an item taken into an empty stage is offered in the next cycle
    p_next_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        (push && occ == OCC_EMPTY) |=> (br_valid != '0) || (br_stall != '0));

    // R7: a stage that stalled and delivered nothing stays stalled
    p_stall_persist_r7: assert property (@(posedge clk) disable iff (rst)
        (up_stall && br_valid == '0) |=> up_stall);

endmodule

// File: tb/fork_stage_test.sv
module fork_stage_test;

    localparam int PERIOD = 10;
    localparam int NB     = 2;
    localparam int W      = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              up_valid = 1'b0;
    logic [W-1:0]      up_data = '0;
    logic              up_stall;
    logic [NB-1:0]     br_valid;
    logic [NB*W-1:0]   br_data;
    logic [NB-1:0]     br_stall = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] model_q [$];
    logic [W-1:0] sent_q  [$];
    int           got_n   [NB];
    logic [W-1:0] seq_ctr = 16'h1000;

    fork_stage #(.BRANCHES(NB), .WIDTH(W)) uut (
        .clk      (clk),
        .rst      (rst),
        .up_valid (up_valid),
        .up_data  (up_data),
        .up_stall (up_stall),
        .br_valid (br_valid),
        .br_data  (br_data),
        .br_stall (br_stall)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive at falling edge, check, then update the model at the rising edge
    task automatic step(input logic v, input logic [W-1:0] d, input logic [NB-1:0] st);
        bit exp_stall, fire_m, push_m;
        @(negedge clk);
        up_valid = v;
        up_data  = d;
        br_stall = st;
        #2;
        exp_stall = (model_q.size() == 2);
        fire_m    = (model_q.size() > 0) && (st == '0);
        push_m    = v && !exp_stall;
        chk(up_stall == exp_stall, "R7/R5 up_stall", up_stall, exp_stall);
        if (st != '0)
            chk(br_valid == '0, "R2 valid suppressed", br_valid, 0);
        else
            chk(br_valid == (fire_m ? {NB{1'b1}} : '0), "R3/R8 valid", br_valid, fire_m);
        if (fire_m)
            for (int i = 0; i < NB; i++)
                chk(br_data[i*W +: W] == model_q[0], "R3/R9 head data", br_data[i*W +: W], model_q[0]);
        for (int i = 0; i < NB; i++) begin
            if (br_valid[i] && !br_stall[i]) begin
                if (got_n[i] < sent_q.size())
                    chk(br_data[i*W +: W] == sent_q[got_n[i]], "R4 branch sequence",
                        br_data[i*W +: W], sent_q[got_n[i]]);
                else
                    chk(1'b0, "R4 repeat delivery", got_n[i], sent_q.size());
                got_n[i]++;
            end
        end
        if (push_m) sent_q.push_back(d);
        @(posedge clk);
        if (fire_m) void'(model_q.pop_front());
        if (push_m) model_q.push_back(d);
    endtask

    task automatic rand_phase(input int cycles, input int stall_pct, input int valid_pct);
        for (int c = 0; c < cycles; c++) begin
            logic [NB-1:0] st;
            for (int i = 0; i < NB; i++) st[i] = (($urandom % 100) < stall_pct);
            seq_ctr++;
            step((($urandom % 100) < valid_pct), seq_ctr, st);
        end
    endtask

    initial begin
        for (int i = 0; i < NB; i++) got_n[i] = 0;
        // R1: reset with busy inputs
        rst = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            up_valid = 1'b1;
            up_data  = 16'hDEAD;
            br_stall = '0;
            #2;
            chk(br_valid == '0, "R1 valid in reset", br_valid, 0);
            chk(up_stall == 1'b0, "R1 stall in reset", up_stall, 0);
        end
        @(negedge clk);
        rst = 1'b0;
        up_valid = 1'b0;
        #2;
        chk(br_valid == '0, "R1 valid after reset", br_valid, 0);
        chk(up_stall == 1'b0, "R1 stall after reset", up_stall, 0);
        @(posedge clk);

        // R5: empty stage ignores branch stalls
        step(1'b0, 16'h0, {NB{1'b1}});
        step(1'b0, 16'h0, 2'b01);
        // R6/R7: fill while stalled, extra offers must be dropped
        step(1'b1, 16'hA001, {NB{1'b1}});
        step(1'b1, 16'hA002, 2'b10);
        step(1'b1, 16'hA003, 2'b01);
        step(1'b1, 16'hA004, {NB{1'b1}});
        // R8/R4: release, drain in order
        step(1'b0, 16'h0, '0);
        step(1'b0, 16'h0, '0);
        step(1'b0, 16'h0, '0);
        // R8: single item through an empty stage
        step(1'b1, 16'hB001, '0);
        step(1'b0, 16'h0, '0);

        rand_phase(500, 10, 80);
        rand_phase(500, 50, 90);
        rand_phase(500, 90, 60);
        rand_phase(300, 30, 100);

        for (int c = 0; c < 6; c++) step(1'b0, 16'h0, '0);
        for (int i = 0; i < NB; i++)
            chk(got_n[i] == sent_q.size(), "R4 branch count", got_n[i], sent_q.size());

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule